// File: doc/BRIEF.md
# Shared-Window Control Header Validator

This block reads the 32-byte control header that sits at the start of a memory window shared by two processors. After a `start` pulse it fetches the header one byte per cycle through a simple read port. It then checks the header and reports a single verdict with a reason code. The verdict covers the fixed ASCII magic word "MCTP", the placement of the receive and transmit regions inside a window whose size is an input, and the version fields of the two sides. The decoded region offsets and sizes and the computed negotiated version are presented on output registers. They hold their values until the next run.

All multi-byte header fields are big-endian. Header layout by byte offset:
- 0..3: magic.
- 4..5: first side minimum version.
- 6..7: first side current version.
- 8..9: second side minimum version.
- 10..11: second side current version.
- 12..13: negotiated-version slot. It is ignored; the block computes its own.
- 14..15: padding.
- 16..19: receive offset.
- 20..23: receive size.
- 24..27: transmit offset.
- 28..31: transmit size.

Offsets are counted from the window start. The read port has one cycle of latency: the byte addressed while `rd_en` is high must be on `rd_data` in the following cycle.

The controller is a five-state machine:
- IDLE: the block waits for `start`.
- FETCH: 32 reads are issued.
- DRAIN: the last byte is captured.
- EVAL: the results are registered.
- REPORT: `done` is pulsed.

Transitions:
- IDLE to FETCH when `start` is seen.
- FETCH to DRAIN after address 31 is issued.
- DRAIN to EVAL unconditionally.
- EVAL to REPORT unconditionally.
- REPORT to IDLE unconditionally.

Top module: `ctrl_hdr_check`

## Requirements
- R1: After reset `done`, `pass`, `fail`, `busy` and `rd_en` are 0, and `fail_code` is 0.
- R2: A `start` seen in IDLE causes `rd_en` to be high for exactly 32 consecutive cycles, beginning in the cycle after the accepting edge, with `rd_addr` going 0, 1, ..., 31. A `start` while `busy` is high is ignored.
- R3: `done` is high for exactly one cycle, the 35th cycle counted from the cycle in which `start` is applied, and `busy` is low from then on.
- R4: The outputs decode the header big-endian as laid out above. `rx_off`=bytes 16..19, `rx_size`=20..23, `tx_off`=24..27, `tx_size`=28..31. `neg_ver` is the smaller of the two current versions (bytes 6..7 and 10..11).
- R5: A magic word other than 0x4D435450 gives `fail_code`=1.
- R6: A region whose offset plus size, computed 33 bits wide so that 32-bit wraparound counts as too far, exceeds `win_size` gives `fail_code`=3.
- R7: A region size below 68 bytes (a 64-byte payload plus a 4-byte length field) gives `fail_code`=4.
- R8: A region that starts below byte 32 (inside the header) or that intersects the other region gives `fail_code`=2. Regions that only touch end to start are legal.
- R9: A computed negotiated version below either side's minimum gives `fail_code`=5.
- R10: When several faults exist, the code follows the priority magic, then window, then size, then overlap, then version. With no fault, `pass`=1, `fail`=0 and `fail_code`=0. Otherwise `pass`=0 and `fail`=1. While `done` is high exactly one of `pass` and `fail` is set.
- R11: The verdict, code and decoded outputs stay unchanged from `done` until the next accepted `start`, even if the window contents change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a validation run (taken only when idle) |
| win_size | input | 32 | Window size in bytes, sampled at start |
| rd_en | output | 1 | Read request to the window memory |
| rd_addr | output | ADDR_W | Byte address of the request |
| rd_data | input | 8 | Read data, valid one cycle after the request |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Header valid |
| fail | output | 1 | Header invalid |
| fail_code | output | 3 | 0 none, 1 magic, 2 overlap, 3 outside window, 4 too small, 5 version |
| rx_off | output | 32 | Decoded receive offset |
| rx_size | output | 32 | Decoded receive size |
| tx_off | output | 32 | Decoded transmit offset |
| tx_size | output | 32 | Decoded transmit size |
| neg_ver | output | 16 | Computed negotiated version |

## Verification
The hardest cases to reach from the ports are those where several faults coincide, so that only the priority order decides the code. Among them, the wraparound case is one where offset plus size overflows 32 bits and would look small if summed at operand width. The bench sweeps both region offsets over a grid that straddles the header boundary and each other's edges, using several sizes around the 68-byte minimum. It also places one region near the top of the 32-bit address space and corrupts the magic while other faults are present. A second `start` is injected in the middle of a fetch to show that it changes neither the read sequence nor the timing.

// File: rtl/hdr_chk_pkg.sv
package hdr_chk_pkg;

    localparam int          HDR_BYTES = 32;
    localparam logic [31:0] HDR_MAGIC = 32'h4D43_5450;

    // byte positions of the header fields
    localparam int POS_MAGIC    = 0;
    localparam int POS_A_MIN    = 4;
    localparam int POS_A_CUR    = 6;
    localparam int POS_B_MIN    = 8;
    localparam int POS_B_CUR    = 10;
    localparam int POS_REGIONS  = 16;
    localparam int REGION_PITCH = 8;
    localparam int NUM_REGIONS  = 2;

    typedef enum logic [2:0] {
        FC_NONE    = 3'd0,
        FC_MAGIC   = 3'd1,
        FC_OVERLAP = 3'd2,
        FC_WINDOW  = 3'd3,
        FC_SMALL   = 3'd4,
        FC_VERSION = 3'd5
    } fail_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_EVAL,
        ST_REPORT
    } fetch_state_e;

    function automatic logic [31:0] be32(input logic [HDR_BYTES*8-1:0] h, input int at);
        return {h[8*at +: 8], h[8*(at+1) +: 8], h[8*(at+2) +: 8], h[8*(at+3) +: 8]};
    endfunction

    function automatic logic [15:0] be16(input logic [HDR_BYTES*8-1:0] h, input int at);
        return {h[8*at +: 8], h[8*(at+1) +: 8]};
    endfunction

endpackage

// File: rtl/hdr_fetch_fsm.sv
module hdr_fetch_fsm
    import hdr_chk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   rd_en,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic [7:0]             rd_data,
    output logic [HDR_BYTES*8-1:0] hdr_flat,
    output logic                   accept,
    output logic                   eval_go,
    output logic                   done,
    output logic                   busy
);

    localparam int CNT_W = $clog2(HDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_BYTES - 1);

    fetch_state_e           state_q, state_d;
    logic [CNT_W-1:0]       issue_q;
    logic [CNT_W-1:0]       cap_q;
    logic                   vld_q;
    logic [HDR_BYTES*8-1:0] hdr_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  if (issue_q == LAST_IDX) state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_EVAL;
            ST_EVAL:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        rd_en   = (state_q == ST_FETCH);
        rd_addr = ADDR_W'(issue_q);
        accept  = (state_q == ST_IDLE) && start;
        eval_go = (state_q == ST_EVAL);
        done    = (state_q == ST_REPORT);
        busy    = (state_q != ST_IDLE);
    end

    // address counter and byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q <= '0;
            cap_q   <= '0;
            vld_q   <= 1'b0;
            hdr_q   <= '0;
        end else begin
            vld_q <= rd_en;
            if (accept) begin
                issue_q <= '0;
                cap_q   <= '0;
            end else begin
                if (rd_en) issue_q <= issue_q + 1'b1;
                if (vld_q) begin
                    hdr_q[8*cap_q +: 8] <= rd_data;
                    cap_q <= cap_q + 1'b1;
                end
            end
        end
    end

    assign hdr_flat = hdr_q;

    // R2
    fetch_first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> rd_addr == '0);

    // R2
    fetch_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

endmodule

// File: rtl/hdr_region_bound.sv
module hdr_region_bound #(
    parameter int OFF_W     = 32,
    parameter int HDR_LEN   = 32,
    parameter int MIN_BYTES = 68
) (
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W-1:0] size,
    input  logic [OFF_W-1:0] win_size,
    output logic [OFF_W:0]   end_pos,
    output logic             out_of_win,
    output logic             too_small,
    output logic             hits_hdr
);

    always_comb begin
        end_pos    = {1'b0, off} + {1'b0, size};
        out_of_win = end_pos > {1'b0, win_size};
        too_small  = size < OFF_W'(MIN_BYTES);
        hits_hdr   = off < OFF_W'(HDR_LEN);
    end

endmodule

// File: rtl/hdr_version_pick.sv
module hdr_version_pick #(
    parameter int VER_W = 16
) (
    input  logic [VER_W-1:0] a_min,
    input  logic [VER_W-1:0] a_cur,
    input  logic [VER_W-1:0] b_min,
    input  logic [VER_W-1:0] b_cur,
    output logic [VER_W-1:0] agreed,
    output logic             agreed_ok
);

    always_comb begin
        agreed    = (a_cur < b_cur) ? a_cur : b_cur;
        agreed_ok = (agreed >= a_min) && (agreed >= b_min);
    end

endmodule

// File: rtl/ctrl_hdr_check.sv
module ctrl_hdr_check
    import hdr_chk_pkg::*;
#(
    parameter int ADDR_W          = 16,
    parameter int MIN_PAYLOAD     = 64,
    parameter int LEN_FIELD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       win_size,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [2:0]        fail_code,
    output logic [31:0]       rx_off,
    output logic [31:0]       rx_size,
    output logic [31:0]       tx_off,
    output logic [31:0]       tx_size,
    output logic [15:0]       neg_ver
);

    localparam int OFF_W      = 32;
    localparam int MIN_REGION = MIN_PAYLOAD + LEN_FIELD_BYTES;

    logic [HDR_BYTES*8-1:0] hdr_flat;
    logic                   accept, eval_go;
    logic [OFF_W-1:0]       win_q;

    hdr_fetch_fsm #(.ADDR_W(ADDR_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hdr_flat (hdr_flat),
        .accept   (accept),
        .eval_go  (eval_go),
        .done     (done),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      win_q <= '0;
        else if (accept) win_q <= win_size;
    end

    // per-region placement checks (index 0 = receive, 1 = transmit)
    logic [OFF_W-1:0] r_off  [NUM_REGIONS];
    logic [OFF_W-1:0] r_size [NUM_REGIONS];
    logic [OFF_W:0]   r_end  [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] r_win_bad, r_small, r_hdr_hit;

    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
        assign r_off[gi]  = be32(hdr_flat, POS_REGIONS + REGION_PITCH*gi);
        assign r_size[gi] = be32(hdr_flat, POS_REGIONS + REGION_PITCH*gi + 4);

        hdr_region_bound #(
            .OFF_W     (OFF_W),
            .HDR_LEN   (HDR_BYTES),
            .MIN_BYTES (MIN_REGION)
        ) u_bound (
            .off        (r_off[gi]),
            .size       (r_size[gi]),
            .win_size   (win_q),
            .end_pos    (r_end[gi]),
            .out_of_win (r_win_bad[gi]),
            .too_small  (r_small[gi]),
            .hits_hdr   (r_hdr_hit[gi])
        );
    end

    logic pair_hit;
    assign pair_hit = ({1'b0, r_off[0]} < r_end[1]) && ({1'b0, r_off[1]} < r_end[0]);

    logic [15:0] ver_agreed;
    logic        ver_ok;

    hdr_version_pick #(.VER_W(16)) u_ver (
        .a_min     (be16(hdr_flat, POS_A_MIN)),
        .a_cur     (be16(hdr_flat, POS_A_CUR)),
        .b_min     (be16(hdr_flat, POS_B_MIN)),
        .b_cur     (be16(hdr_flat, POS_B_CUR)),
        .agreed    (ver_agreed),
        .agreed_ok (ver_ok)
    );

    // prioritised verdict
    fail_code_e code_c;
    always_comb begin
        if (be32(hdr_flat, POS_MAGIC) != HDR_MAGIC) code_c = FC_MAGIC;
        else if (|r_win_bad)                        code_c = FC_WINDOW;
        else if (|r_small)                          code_c = FC_SMALL;
        else if ((|r_hdr_hit) || pair_hit)          code_c = FC_OVERLAP;
        else if (!ver_ok)                           code_c = FC_VERSION;
        else                                        code_c = FC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass      <= 1'b0;
            fail      <= 1'b0;
            fail_code <= 3'd0;
            rx_off    <= '0;
            rx_size   <= '0;
            tx_off    <= '0;
            tx_size   <= '0;
            neg_ver   <= '0;
        end else if (eval_go) begin
            pass      <= (code_c == FC_NONE);
            fail      <= (code_c != FC_NONE);
            fail_code <= code_c;
            rx_off    <= r_off[0];
            rx_size   <= r_size[0];
            tx_off    <= r_off[1];
            tx_size   <= r_size[1];
            neg_ver   <= ver_agreed;
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass ^ fail));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({pass, fail, fail_code, rx_off, tx_off, neg_ver}));

endmodule

// File: tb/ctrl_hdr_check_bench.sv
`timescale 1ns/1ps
module ctrl_hdr_check_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] win_size = 32'd0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = 8'h00;
    logic        busy, done, pass, fail;
    logic [2:0]  fail_code;
    logic [31:0] rx_off, rx_size, tx_off, tx_size;
    logic [15:0] neg_ver;

    always #2 clk = ~clk;

    ctrl_hdr_check u_ctrl_hdr_check (
        .clk(clk), .rst_n(rst_n), .start(start), .win_size(win_size),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_code(fail_code),
        .rx_off(rx_off), .rx_size(rx_size), .tx_off(tx_off), .tx_size(tx_size),
        .neg_ver(neg_ver)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // window memory model, one-cycle read latency
    logic [7:0] mem [32];
    int reads = 0;
    int seq_bad = 0;
    int exp_addr = 0;

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr[4:0]];
            if (int'(rd_addr) != exp_addr) seq_bad++;
            exp_addr++;
            reads++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put32(input int at, input logic [31:0] v);
        mem[at] = v[31:24]; mem[at+1] = v[23:16]; mem[at+2] = v[15:8]; mem[at+3] = v[7:0];
    endtask

    task automatic put16(input int at, input logic [15:0] v);
        mem[at] = v[15:8]; mem[at+1] = v[7:0];
    endtask

    logic [31:0] h_mg, h_ro, h_rs, h_to, h_ts;
    logic [15:0] h_amin, h_acur, h_bmin, h_bcur;

    task automatic load(input logic [31:0] mg, input logic [15:0] amin, acur, bmin, bcur,
                        input logic [31:0] ro, rs, to, ts);
        h_mg = mg; h_amin = amin; h_acur = acur; h_bmin = bmin; h_bcur = bcur;
        h_ro = ro; h_rs = rs; h_to = to; h_ts = ts;
        put32(0, mg); put16(4, amin); put16(6, acur); put16(8, bmin); put16(10, bcur);
        put16(12, 16'hEEEE); put16(14, 16'h0000);
        put32(16, ro); put32(20, rs); put32(24, to); put32(28, ts);
    endtask

    // expected code from the requirements (R5..R10)
    function automatic int exp_code(input logic [31:0] win);
        logic [32:0] re, te;
        logic [15:0] nv;
        re = {1'b0, h_ro} + {1'b0, h_rs};
        te = {1'b0, h_to} + {1'b0, h_ts};
        nv = (h_acur < h_bcur) ? h_acur : h_bcur;
        if (h_mg != 32'h4D435450) return 1;
        if (re > {1'b0, win} || te > {1'b0, win}) return 3;
        if (h_rs < 68 || h_ts < 68) return 4;
        if (h_ro < 32 || h_to < 32) return 2;
        if ({1'b0, h_ro} < te && {1'b0, h_to} < re) return 2;
        if (nv < h_amin || nv < h_bmin) return 5;
        return 0;
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            1: return "R5";
            2: return "R8";
            3: return "R6";
            4: return "R7";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic run(input logic [31:0] win, input bit restart);
        int cyc;
        int ec;
        logic [15:0] nv;
        win_size = win;
        reads = 0; seq_bad = 0; exp_addr = 0;
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (restart && cyc == 10) start = 1'b1;
        end while (!done && cyc < 100);
        start = 1'b0;
        ec = exp_code(win);
        nv = (h_acur < h_bcur) ? h_acur : h_bcur;
        check(cyc == 35, "R3", "done cycle", cyc, 35);
        check(reads == 32 && seq_bad == 0, "R2", "read sequence", reads, 32);
        check(int'(fail_code) == ec, tag_of(ec), "fail_code", fail_code, ec);
        check(pass == (ec == 0) && fail == (ec != 0), "R10", "pass/fail",
              {pass, fail}, {ec == 0, ec != 0});
        check(rx_off == h_ro && rx_size == h_rs && tx_off == h_to && tx_size == h_ts,
              "R4", "decoded regions", rx_off, h_ro);
        check(neg_ver == nv, "R4", "neg_ver", neg_ver, nv);
        @(negedge clk);
        check(!done && !busy, "R3", "done one cycle", {done, busy}, 0);
    endtask

    initial begin
        #700000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int offs [20] = '{0, 16, 28, 31, 32, 33, 48, 64, 80, 96, 99, 100, 101,
                          112, 128, 144, 160, 176, 188, 192};
        int szs [3] = '{67, 68, 72};
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1
        check(!done && !pass && !fail && !busy && !rd_en && fail_code == 0,
              "R1", "reset outputs", {done, pass, fail, busy, rd_en, fail_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // nominal pass
        load(32'h4D435450, 1, 2, 1, 3, 32, 100, 132, 100);
        run(512, 0);
        // R2 restart ignored mid-fetch
        run(512, 1);

        // R11: results held while memory changes
        load(32'h00000000, 9, 9, 9, 9, 0, 0, 0, 0);
        repeat (6) @(negedge clk);
        check(pass && fail_code == 0 && rx_off == 32 && neg_ver == 2, "R11", "held verdict",
              {pass, fail_code}, {1'b1, 3'd0});

        // placement sweep (R6 R7 R8 R10)
        for (int a = 0; a < 20; a++)
            for (int b = 0; b < 20; b++)
                for (int s = 0; s < 3; s++) begin
                    load(32'h4D435450, 1, 1, 1, 1, offs[a], szs[s], offs[b], 68);
                    run(256, 0);
                end

        // window edge sweep (R6): regions end at 100 and 168
        for (int w = 160; w <= 176; w++) begin
            load(32'h4D435450, 1, 1, 1, 1, 32, 68, 100, 68);
            run(w, 0);
        end

        // wraparound (R6)
        load(32'h4D435450, 1, 1, 1, 1, 32'hFFFF_FFF0, 32'h100, 40, 68);
        run(32'hFFFF_FFFF, 0);
        load(32'h4D435450, 1, 1, 1, 1, 40, 68, 32'h8000_0000, 32'h8000_0000);
        run(32'hFFFF_FFFF, 0);

        // version sweep (R9 R4)
        for (int am = 1; am <= 3; am++)
            for (int ac = 1; ac <= 3; ac++)
                for (int bm = 1; bm <= 3; bm++)
                    for (int bc = 1; bc <= 3; bc++) begin
                        load(32'h4D435450, am, ac, bm, bc, 32, 68, 100, 68);
                        run(256, 0);
                    end

        // magic corruption with other faults present (R5 R10)
        for (int k = 0; k < 4; k++) begin
            logic [31:0] m;
            m = 32'h4D435450 ^ (32'h1 << (8*k + k));
            load(m, 3, 1, 1, 1, 0, 10, 0, 10);
            run(40, 0);
        end
        // priority: size beats overlap and version (R10)
        load(32'h4D435450, 3, 1, 1, 1, 0, 10, 0, 10);
        run(256, 0);
        // priority: overlap beats version (R10)
        load(32'h4D435450, 3, 1, 1, 1, 40, 68, 60, 68);
        run(256, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule